// File: doc/BRIEF.md
# Four-Channel DAC Code Register Bank

This block is the digital front end of a four-channel, 12-bit converter. It keeps one 12-bit code register per channel. A shared host bus feeds all four registers, and each register has its own active-low select line. When a select is low at a rising clock edge, that channel's register takes the word on the bus. When the select is high, the register keeps its value. Several selects may be low in the same cycle, and each selected channel then takes the same word. This gives a broadcast write. The level-sensitive latch is modelled as an enable sampled on the clock. A select held low for several cycles therefore makes its register follow the bus one cycle behind.

A small host adapter turns the bus into a 12-bit word. A two-bit mode input picks one of three forms:
- The word sits in the low 12 bits of a 16-bit bus (an integer from 0 to 4095).
- The word sits in the high 12 bits (a fraction of full scale).
- The word arrives as two bytes on the low 8 bits. The first byte is staged, and the second byte completes the word and loads it into the channels selected at that time.

Codes are offset binary, with 0x800 at mid-scale. Each channel also presents a two's-complement view of its code.

The bus has no valid/ready handshake. It is always ready: every cycle in which a select is low is one accepted transfer. There is no back-pressure, so the host must not present a transfer it does not intend.

Top module: `quad_dac_bank`

## Requirements
- R1: A synchronous reset sets all four codes to 0x800. The signed views then read 0. A reset asserted mid-run restores this state at the next edge.
- R2: In a cycle where every select is high, no code changes, whatever the bus holds.
- R3: A single select low at an edge loads only that channel. The new code is visible after that edge, and the other three channels keep their values.
- R4: Any combination of low selects loads every selected channel with the same word. All four low loads every channel.
- R5: A select held low across several edges makes its code follow the bus. Each edge loads the word present in the preceding cycle.
- R6: Mode 0 (and mode 3) takes the word from bus bits [11:0]. Bus bits [15:12] are ignored.
- R7: Mode 1 takes the word from bus bits [15:4]. Bus bits [3:0] are ignored.
- R8: In mode 2, cycles with at least one select low alternate between first and second byte.
  - A first byte stores bus bits [7:0] and changes no code.
  - A second byte loads {bus bits [3:0], stored byte} into the channels selected in that cycle.
  - Bus bits [15:4] of the second byte are ignored.
- R9: Each signed output equals its code with bit 11 inverted, which is two's complement.
- R10: Any cycle spent outside mode 2 cancels a half-finished byte pair. The next mode-2 select cycle is then a first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_mode_i | input | 2 | 0/3 low-justified, 1 high-justified, 2 byte pairs |
| host_data_i | input | 16 | Shared host data bus |
| sel_n_i | input | 4 | Active-low channel selects, bit n for channel n |
| code_o | output | 48 | Offset-binary codes, channel n in bits [12n+11:12n] |
| sval_o | output | 48 | Two's-complement views, same packing as code_o |

## Verification
Every result is due exactly one rising edge after the cycle that presents it: a code load, a hold, a reset and the completion of a byte pair. A first byte changes no output. The signed view follows its code with no further delay. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares all eight outputs at the following falling edge, which is one register stage after the stimulus. Random traffic mixes modes and select patterns against the same model, so byte-pair phase and mode changes are tracked the same way.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;
  typedef enum logic [1:0] {
    MD_RIGHT = 2'd0,
    MD_LEFT  = 2'd1,
    MD_BYTE  = 2'd2,
    MD_ALT   = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/qdac_host_if.sv
`timescale 1ns/1ps
module qdac_host_if
  import qdac_pkg::*;
#(
  parameter int W      = 12,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8,
  parameter int NCH    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic [NCH-1:0]   sel_n_i,
  output logic [W-1:0]     word_o,
  output logic [NCH-1:0]   ld_o
);
  localparam int HI_W     = W - BYTE_W;
  localparam int LEFT_LSB = BUS_W - W;

  bus_mode_e          mode;
  logic               byte_md;
  logic               any_sel;
  logic               phase_q;
  logic [BYTE_W-1:0]  stage_q;

  assign mode    = bus_mode_e'(mode_i);
  assign byte_md = (mode == MD_BYTE);
  assign any_sel = ~&sel_n_i;

  // byte pairing: phase 0 waits for the low byte, phase 1 for the high part
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      stage_q <= '0;
    end else if (!byte_md) begin
      phase_q <= 1'b0;
    end else if (any_sel) begin
      if (!phase_q) begin
        stage_q <= data_i[BYTE_W-1:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (mode)
      MD_LEFT: word_o = data_i[BUS_W-1:LEFT_LSB];
      MD_BYTE: word_o = {data_i[HI_W-1:0], stage_q};
      default: word_o = data_i[W-1:0];
    endcase
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ld
    assign ld_o[g] = ~sel_n_i[g] & (~byte_md | phase_q);
  end

  // R8
  first_byte_noload_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_md && !phase_q) |-> (ld_o == '0));

  // R8
  pair_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_md && any_sel && !phase_q) |=> phase_q);

  // R10
  phase_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_md |=> !phase_q);
endmodule

// File: rtl/qdac_chan.sv
`timescale 1ns/1ps
module qdac_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] sval_o
);
  localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)       code_q <= MID_CODE;
    else if (ld_i) code_q <= word_i;
  end

  assign code_o = code_q;
  assign sval_o = {~code_q[W-1], code_q[W-2:0]};

  // R1
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (code_o == MID_CODE));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> $stable(code_o));

  // R5
  follow_chk: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (code_o == $past(word_i)));
endmodule

// File: rtl/quad_dac_bank.sv
`timescale 1ns/1ps
module quad_dac_bank #(
  parameter int W      = 12,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8,
  parameter int NCH    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         bus_mode_i,
  input  logic [BUS_W-1:0]   host_data_i,
  input  logic [NCH-1:0]     sel_n_i,
  output logic [NCH*W-1:0]   code_o,
  output logic [NCH*W-1:0]   sval_o
);
  logic [W-1:0]   word;
  logic [NCH-1:0] ld;

  qdac_host_if #(.W(W), .BUS_W(BUS_W), .BYTE_W(BYTE_W), .NCH(NCH)) u_host (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (bus_mode_i),
    .data_i  (host_data_i),
    .sel_n_i (sel_n_i),
    .word_o  (word),
    .ld_o    (ld)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qdac_chan #(.W(W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .ld_i   (ld[c]),
      .word_i (word),
      .code_o (code_o[c*W +: W]),
      .sval_o (sval_o[c*W +: W])
    );
  end

  // R4
  bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_mode_i != 2'd2 && sel_n_i == '0) |=> (code_o == {NCH{$past(word)}}));
endmodule

// File: tb/quad_dac_bank_test.sv
`timescale 1ns/1ps
module quad_dac_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [15:0] data = '0;
  logic [3:0]  sel_n = 4'hF;
  logic [47:0] code_o, sval_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [11:0] m_code [4];
  logic        m_phase;
  logic [7:0]  m_stage;

  always #2 clk = ~clk;

  quad_dac_bank uut (
    .clk(clk), .rst(rst), .bus_mode_i(mode), .host_data_i(data),
    .sel_n_i(sel_n), .code_o(code_o), .sval_o(sval_o)
  );

  function automatic logic [11:0] word_of(logic [1:0] md, logic [15:0] d, logic [7:0] stg);
    case (md)
      2'd1:    return d[15:4];
      2'd2:    return {d[3:0], stg};
      default: return d[11:0];
    endcase
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 4; i++) m_code[i] = 12'h800;
      m_phase = 1'b0; m_stage = '0;
    end else if (mode != 2'd2) begin
      for (int i = 0; i < 4; i++) if (!sel_n[i]) m_code[i] = word_of(mode, data, m_stage);
      m_phase = 1'b0;
    end else if (sel_n != 4'hF) begin
      if (!m_phase) begin
        m_stage = data[7:0]; m_phase = 1'b1;
      end else begin
        for (int i = 0; i < 4; i++) if (!sel_n[i]) m_code[i] = word_of(mode, data, m_stage);
        m_phase = 1'b0;
      end
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) begin
      logic [11:0] ac, as, es;
      ac = code_o[i*12 +: 12];
      as = sval_o[i*12 +: 12];
      es = m_code[i] ^ 12'h800;
      n_tests++;
      if (ac !== m_code[i]) begin
        n_fail++;
        $display("FAIL %s ch%0d code actual %h expected %h", tag, i, ac, m_code[i]);
      end
      n_tests++;
      if (as !== es) begin
        n_fail++;
        $display("FAIL R9 ch%0d signed actual %h expected %h", i, as, es);
      end
    end
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(logic r, logic [1:0] md, logic [15:0] d, logic [3:0] s, string tag);
    rst = r; mode = md; data = d; sel_n = s;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    step(1, 0, 16'h0000, 4'hF, "R1");
    step(0, 0, 16'hFFFF, 4'hF, "R2");
    step(0, 0, 16'hA5C3, 4'hE, "R3");          // R6 upper nibble ignored
    step(0, 0, 16'h1234, 4'hB, "R3");
    step(0, 0, 16'h0FFF, 4'h0, "R4");
    step(0, 0, 16'h0123, 4'h5, "R4");
    step(0, 3, 16'hF456, 4'h7, "R6");
    step(0, 0, 16'h0111, 4'hD, "R5");
    step(0, 0, 16'h0222, 4'hD, "R5");
    step(0, 0, 16'h0333, 4'hD, "R5");
    step(0, 1, 16'hABCD, 4'hD, "R7");
    step(0, 1, 16'h0003, 4'hE, "R7");
    step(0, 2, 16'hEE12, 4'hB, "R8");          // first byte: no change
    step(0, 2, 16'h0000, 4'hF, "R8");          // idle keeps pair open
    step(0, 2, 16'hFFF7, 4'h3, "R8");          // ch2, ch3 get 0x712
    step(0, 2, 16'h0099, 4'hE, "R10");         // first byte
    step(0, 0, 16'h0000, 4'hF, "R10");         // leave byte mode
    step(0, 2, 16'h0044, 4'hE, "R10");         // first byte again: no load
    step(0, 2, 16'h0005, 4'hE, "R10");         // ch0 = 0x544
    step(1, 0, 16'h0FFF, 4'h0, "R1");
    step(0, 0, 16'h0000, 4'hF, "R2");
    for (int k = 0; k < 400; k++) begin
      logic [1:0] md;
      logic [3:0] s;
      md = 2'($urandom_range(0, 3));
      s  = 4'($urandom);
      if ($urandom_range(0, 3) == 0) s = 4'hF;
      step(($urandom_range(0, 99) == 0), md, 16'($urandom), s, "R4");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule